// File: doc/BRIEF.md
# DMA End-of-Process Status and Interrupt Unit

This block belongs to a SCSI bus controller. It watches the four active-low DMA handshake lines (end-of-process, DMA acknowledge, I/O read, I/O write) and decides when a genuine end-of-process pulse has happened. A pulse counts only when end-of-process, acknowledge and at least one of the two strobes are all asserted together for a minimum time while DMA mode is on. A pulse that counts latches an end-of-DMA flag, and it can also raise an interrupt request.

The block also builds two readable bytes. The first is a status byte that combines the latched flags with status bits from the rest of the controller. The second is a byte that mirrors the live SCSI control lines. The minimum pulse time is set in nanoseconds and converted to a cycle count from the clock period, with rounding up. The handshake lines are asynchronous, so they pass through a two-stage synchroniser before they are qualified.

Top module: `eop_status_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the end-of-DMA flag (status bit 7) and the interrupt request (`irq`, status bit 4).
- R2: No end-of-process event is recognised while `dmaMode` is low.
- R3: The overlap condition is `eopN`, `dackN` and at least one of `iorN`/`iowN` all low. After the two-stage synchroniser, this condition must hold on QUAL_CYCLES consecutive clock edges, where QUAL_CYCLES is the minimum pulse time divided by the clock period, rounded up (5 by default: 100 ns at 20 ns). The count restarts from zero if the condition drops early. If neither strobe is low, the overlap does not count.
- R4: A qualifying pulse sets status bit 7 at the edge where the QUAL_CYCLES-th consecutive qualifying sample is taken. A pulse that is held longer produces only that one event.
- R5: An event also sets `irq` only when `eopIrqEn` is high in that cycle. When `eopIrqEn` is low, an event sets bit 7 and leaves `irq` unchanged.
- R6: Bit 7 and `irq` hold their value until an edge where `intrReset` is high or `dmaMode` is low, and that edge clears both. If an event and a clear fall on the same edge, the event wins.
- R7: The status byte is registered. Its bit order from bit 0 up is: ack, atn, busy error, phase match, interrupt request, parity error, DMA request, end of DMA. Every bit except 4 and 7 copies its input as it was at the previous edge.
- R8: `busStatusByte` copies `busLines` as sampled at the previous edge. The bit order from bit 0 up is: data parity, select, I/O, C/D, message, request, busy, reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eopN | input | 1 | End-of-process, active low, asynchronous |
| dackN | input | 1 | DMA acknowledge, active low, asynchronous |
| iorN | input | 1 | I/O read strobe, active low, asynchronous |
| iowN | input | 1 | I/O write strobe, active low, asynchronous |
| dmaMode | input | 1 | DMA mode enable |
| eopIrqEn | input | 1 | End-of-process interrupt enable |
| intrReset | input | 1 | Strobe that clears the end-of-DMA flag and the interrupt |
| ackLine | input | 1 | Acknowledge line, asserted level |
| atnLine | input | 1 | Attention line, asserted level |
| busyErr | input | 1 | Busy-error status from the bus monitor |
| phaseMatch | input | 1 | Phase-match status |
| parityErr | input | 1 | Parity-error status |
| dmaReq | input | 1 | DMA request status |
| busLines | input | 8 | Live SCSI control lines, asserted levels, in R8 order |
| statusByte | output | 8 | Bus-and-status byte (R7) |
| busStatusByte | output | 8 | Current bus-status byte (R8) |
| irq | output | 1 | Interrupt request |

## Verification
Each output has a fixed latency. The two mirrored bytes and the live status bits appear one edge after the inputs are sampled. Bit 7 and `irq` change QUAL_CYCLES+1 edges after the first edge at which the raw overlap is present: two edges for the synchroniser, then QUAL_CYCLES qualifying samples, with the last of those samples being the setting edge. Clears take effect on the edge that samples the strobe. The bench runs a behavioural model of this latency on every rising edge, using a queue for the synchroniser delay and an integer for the run length. It compares the outputs 5 ns after that edge, when the registers have settled and before the next negedge drive. Directed pulses just below the length, at the length and above it check the threshold on both sides.

// File: rtl/eop_pkg.sv
package eop_pkg;

  // Strobes from the control module to the datapath, one cycle wide.
  typedef struct packed {
    logic setEnd;    // recognised end-of-process event
    logic setIrq;    // event with the interrupt source enabled
    logic clrFlags;  // clear request (reset strobe or DMA mode off)
  } eopStrobes_t;

  // Bit positions inside the status byte; software decodes these.
  localparam int unsigned ST_ACK    = 0;
  localparam int unsigned ST_ATN    = 1;
  localparam int unsigned ST_BUSY   = 2;
  localparam int unsigned ST_PHASE  = 3;
  localparam int unsigned ST_IRQ    = 4;
  localparam int unsigned ST_PARITY = 5;
  localparam int unsigned ST_DREQ   = 6;
  localparam int unsigned ST_END    = 7;

  // Packing order of the synchronised handshake vector.
  localparam int unsigned HS_EOP  = 3;
  localparam int unsigned HS_DACK = 2;
  localparam int unsigned HS_IOR  = 1;
  localparam int unsigned HS_IOW  = 0;
  localparam int unsigned HS_W    = 4;

endpackage

// File: rtl/eop_sync.sv
module eop_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  // first stage samples the raw pins
  always_ff @(posedge clk) begin
    if (rst) stageQ[0] <= RESET_VAL;
    else     stageQ[0] <= asyncIn;
  end

  // remaining stages form a plain shift chain
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stageQ[s] <= RESET_VAL;
      else     stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/eop_ctrl.sv
module eop_ctrl
  import eop_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        eopN,
  input  logic        dackN,
  input  logic        iorN,
  input  logic        iowN,
  input  logic        dmaMode,
  input  logic        eopIrqEn,
  input  logic        intrReset,
  output eopStrobes_t strobes
);

  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(QUAL_CYCLES);

  logic [HS_W-1:0] rawHs;
  logic [HS_W-1:0] syncHs;
  logic            overlap;
  logic            qualify;
  logic [CNT_W-1:0] runCnt;
  logic            hitNow;

  assign rawHs[HS_EOP]  = eopN;
  assign rawHs[HS_DACK] = dackN;
  assign rawHs[HS_IOR]  = iorN;
  assign rawHs[HS_IOW]  = iowN;

  eop_sync #(
    .WIDTH    (HS_W),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL({HS_W{1'b1}})
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(rawHs),
    .syncOut(syncHs)
  );

  // all lines active low: end-of-process, acknowledge, and one strobe
  assign overlap = ~syncHs[HS_EOP] & ~syncHs[HS_DACK]
                 & (~syncHs[HS_IOR] | ~syncHs[HS_IOW]);
  assign qualify = overlap & dmaMode;

  // run-length counter; saturates so one long pulse fires only once
  always_ff @(posedge clk) begin
    if (rst || !qualify)        runCnt <= '0;
    else if (runCnt != CNT_SAT) runCnt <= runCnt + 1'b1;
  end

  assign hitNow = qualify && (runCnt == CNT_LAST);

  always_comb begin
    strobes.setEnd   = hitNow;
    strobes.setIrq   = hitNow & eopIrqEn;
    strobes.clrFlags = intrReset | ~dmaMode;
  end

endmodule

// File: rtl/eop_datapath.sv
module eop_datapath
  import eop_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  eopStrobes_t strobes,
  input  logic        ackLine,
  input  logic        atnLine,
  input  logic        busyErr,
  input  logic        phaseMatch,
  input  logic        parityErr,
  input  logic        dmaReq,
  input  logic [7:0]  busLines,
  output logic [7:0]  statusByte,
  output logic [7:0]  busStatusByte,
  output logic        irq
);

  logic endFlag;
  logic irqFlag;
  logic [7:0] liveQ;
  logic [7:0] busQ;

  // latched flags: a set beats a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst) begin
      endFlag <= 1'b0;
      irqFlag <= 1'b0;
    end else if (strobes.setEnd) begin
      endFlag <= 1'b1;
      irqFlag <= irqFlag | strobes.setIrq;
    end else if (strobes.clrFlags) begin
      endFlag <= 1'b0;
      irqFlag <= 1'b0;
    end
  end

  // live bits are registered once so the byte is glitch free
  always_ff @(posedge clk) begin
    liveQ <= '0;
    liveQ[ST_ACK]    <= ackLine;
    liveQ[ST_ATN]    <= atnLine;
    liveQ[ST_BUSY]   <= busyErr;
    liveQ[ST_PHASE]  <= phaseMatch;
    liveQ[ST_PARITY] <= parityErr;
    liveQ[ST_DREQ]   <= dmaReq;
    busQ             <= busLines;
  end

  always_comb begin
    statusByte         = liveQ;
    statusByte[ST_IRQ] = irqFlag;
    statusByte[ST_END] = endFlag;
  end

  assign busStatusByte = busQ;
  assign irq           = irqFlag;

endmodule

// File: rtl/eop_status_unit.sv
module eop_status_unit
  import eop_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned MIN_EOP_NS    = 100,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       eopN,
  input  logic       dackN,
  input  logic       iorN,
  input  logic       iowN,
  input  logic       dmaMode,
  input  logic       eopIrqEn,
  input  logic       intrReset,
  input  logic       ackLine,
  input  logic       atnLine,
  input  logic       busyErr,
  input  logic       phaseMatch,
  input  logic       parityErr,
  input  logic       dmaReq,
  input  logic [7:0] busLines,
  output logic [7:0] statusByte,
  output logic [7:0] busStatusByte,
  output logic       irq
);

  localparam int unsigned RAW_CYCLES  = (MIN_EOP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int unsigned QUAL_CYCLES = (RAW_CYCLES < 1) ? 1 : RAW_CYCLES;

  eopStrobes_t strobes;

  eop_ctrl #(
    .QUAL_CYCLES(QUAL_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .eopN     (eopN),
    .dackN    (dackN),
    .iorN     (iorN),
    .iowN     (iowN),
    .dmaMode  (dmaMode),
    .eopIrqEn (eopIrqEn),
    .intrReset(intrReset),
    .strobes  (strobes)
  );

  eop_datapath u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .ackLine      (ackLine),
    .atnLine      (atnLine),
    .busyErr      (busyErr),
    .phaseMatch   (phaseMatch),
    .parityErr    (parityErr),
    .dmaReq       (dmaReq),
    .busLines     (busLines),
    .statusByte   (statusByte),
    .busStatusByte(busStatusByte),
    .irq          (irq)
  );

endmodule

// File: rtl/eop_status_chk.sv
module eop_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       eopN,
  input logic       dackN,
  input logic       iorN,
  input logic       iowN,
  input logic       dmaMode,
  input logic       eopIrqEn,
  input logic       intrReset,
  input logic [7:0] busLines,
  input logic [7:0] statusByte,
  input logic [7:0] busStatusByte,
  input logic       irq
);

  // R6
  end_hold_chk: assert property (@(posedge clk) disable iff (rst)
    statusByte[7] && dmaMode && !intrReset |=> statusByte[7]);

  // R2
  dma_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !dmaMode |=> !statusByte[7] && !irq);

  // R2
  end_needs_dma_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(statusByte[7]) |-> $past(dmaMode));

  // R3
  overlap_seen_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(statusByte[7]) |-> !$past(eopN, 3) && !$past(dackN, 3)
                             && (!$past(iorN, 3) || !$past(iowN, 3)));

  // R5
  irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(eopIrqEn) && statusByte[7]);

  // R8
  bus_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    busStatusByte == $past(busLines));

endmodule

bind eop_status_unit eop_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .eopN         (eopN),
  .dackN        (dackN),
  .iorN         (iorN),
  .iowN         (iowN),
  .dmaMode      (dmaMode),
  .eopIrqEn     (eopIrqEn),
  .intrReset    (intrReset),
  .busLines     (busLines),
  .statusByte   (statusByte),
  .busStatusByte(busStatusByte),
  .irq          (irq)
);

// File: tb/tb_eop_status_unit.sv
`timescale 1ns/1ps
module tb_eop_status_unit;

  localparam int QUAL = 5;  // 100 ns at a 20 ns clock, rounded up

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eopN = 1'b1, dackN = 1'b1, iorN = 1'b1, iowN = 1'b1;
  logic dmaMode = 1'b0, eopIrqEn = 1'b0, intrReset = 1'b0;
  logic ackLine = 1'b0, atnLine = 1'b0, busyErr = 1'b0, phaseMatch = 1'b0;
  logic parityErr = 1'b0, dmaReq = 1'b0;
  logic [7:0] busLines = 8'h00;
  logic [7:0] statusByte, busStatusByte;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  eop_status_unit dut (
    .clk(clk), .rst(rst), .eopN(eopN), .dackN(dackN), .iorN(iorN), .iowN(iowN),
    .dmaMode(dmaMode), .eopIrqEn(eopIrqEn), .intrReset(intrReset),
    .ackLine(ackLine), .atnLine(atnLine), .busyErr(busyErr), .phaseMatch(phaseMatch),
    .parityErr(parityErr), .dmaReq(dmaReq), .busLines(busLines),
    .statusByte(statusByte), .busStatusByte(busStatusByte), .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: queue for the synchroniser, integer run length
  logic [3:0] pipe[$];
  int  runLen = 0;
  bit  expEnd = 1'b0, expIrq = 1'b0, modelLive = 1'b0;
  logic [7:0] expBus;
  logic [5:0] expLive;

  always @(posedge clk) begin
    logic [3:0] syncd;
    bit qual, ev;
    expBus  = busLines;
    expLive = {dmaReq, parityErr, phaseMatch, busyErr, atnLine, ackLine};
    if (rst) begin
      pipe = {4'hF, 4'hF};
      runLen = 0; expEnd = 1'b0; expIrq = 1'b0;
    end else begin
      syncd = pipe[0];
      void'(pipe.pop_front());
      pipe.push_back({eopN, dackN, iorN, iowN});
      qual = dmaMode && !syncd[3] && !syncd[2] && (!syncd[1] || !syncd[0]);
      ev = 1'b0;
      if (qual) begin runLen++; if (runLen == QUAL) ev = 1'b1; end
      else runLen = 0;
      if (ev) begin expEnd = 1'b1; if (eopIrqEn) expIrq = 1'b1; end
      else if (intrReset || !dmaMode) begin expEnd = 1'b0; expIrq = 1'b0; end
    end
    modelLive = 1'b1;
    #5;
    if (!finished) begin
      check("R4 end-of-DMA bit", {7'd0, statusByte[7]}, {7'd0, expEnd});
      check("R5 irq", {7'd0, irq}, {7'd0, expIrq});
      check("R7 status layout", {2'b00, statusByte[6:5], statusByte[3:0]},
            {2'b00, expLive[5:4], expLive[3:0]});
      check("R7 irq bit 4", {7'd0, statusByte[4]}, {7'd0, expIrq});
      check("R8 bus byte", busStatusByte, expBus);
    end
  end

  // random live lines every cycle
  always @(negedge clk) begin
    busLines   <= 8'($urandom);
    {ackLine, atnLine, busyErr, phaseMatch, parityErr, dmaReq} <= 6'($urandom);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int width, bit useIor, bit useIow);
    @(negedge clk);
    eopN = 1'b0; dackN = 1'b0; iorN = !useIor; iowN = !useIow;
    idle(width);
    eopN = 1'b1; dackN = 1'b1; iorN = 1'b1; iowN = 1'b1;
    idle(4);
  endtask

  task automatic strobeClear();
    @(negedge clk); intrReset = 1'b1;
    @(negedge clk); intrReset = 1'b0;
    idle(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    check("R1 reset end bit", {7'd0, statusByte[7]}, 8'd0);
    check("R1 reset irq", {7'd0, irq}, 8'd0);

    dmaMode = 1'b1; eopIrqEn = 1'b1;
    pulse(QUAL - 1, 1'b1, 1'b0);
    check("R3 short pulse ignored", {7'd0, statusByte[7]}, 8'd0);
    pulse(QUAL, 1'b1, 1'b0);
    check("R4 exact pulse sets", {7'd0, statusByte[7]}, 8'd1);
    check("R5 irq on event", {7'd0, irq}, 8'd1);
    pulse(QUAL + 3, 1'b0, 1'b1);
    check("R6 flag holds", {7'd0, statusByte[7]}, 8'd1);
    strobeClear();
    check("R6 strobe clears", {statusByte[7], irq}, 2'b00);

    // broken overlap: the count restarts
    pulse(QUAL - 2, 1'b1, 1'b0);
    pulse(QUAL - 2, 1'b1, 1'b0);
    check("R3 restart", {7'd0, statusByte[7]}, 8'd0);
    // no strobe asserted
    pulse(QUAL + 5, 1'b0, 1'b0);
    check("R3 needs a strobe", {7'd0, statusByte[7]}, 8'd0);

    eopIrqEn = 1'b0;
    pulse(QUAL + 1, 1'b0, 1'b1);
    check("R5 event without irq", {statusByte[7], irq}, 2'b10);

    dmaMode = 1'b0;
    idle(2);
    check("R6 DMA off clears", {7'd0, statusByte[7]}, 8'd0);
    pulse(QUAL + 2, 1'b1, 1'b1);
    check("R2 no event without DMA", {statusByte[7], irq}, 2'b00);

    // long pulse: one event, cleared mid-pulse, stays clear
    dmaMode = 1'b1; eopIrqEn = 1'b1;
    @(negedge clk);
    eopN = 1'b0; dackN = 1'b0; iorN = 1'b0;
    idle(QUAL + 3);
    check("R4 long pulse event", {statusByte[7], irq}, 2'b11);
    intrReset = 1'b1; idle(1); intrReset = 1'b0;
    idle(8);
    check("R4 once per pulse", {statusByte[7], irq}, 2'b00);
    eopN = 1'b1; dackN = 1'b1; iorN = 1'b1;
    idle(3);

    // clear held across the event edge: set wins on that edge
    @(negedge clk); intrReset = 1'b1;
    eopN = 1'b0; dackN = 1'b0; iowN = 1'b0;
    idle(QUAL + 1);
    eopN = 1'b1; dackN = 1'b1; iowN = 1'b1;
    idle(3);
    intrReset = 1'b0;
    idle(2);

    // random phase
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      eopN      = ($urandom % 8) == 0 ? ~eopN : eopN;
      dackN     = ($urandom % 8) == 0 ? ~dackN : dackN;
      iorN      = ($urandom % 6) == 0 ? ~iorN : iorN;
      iowN      = ($urandom % 6) == 0 ? ~iowN : iowN;
      dmaMode   = ($urandom % 60) != 0;
      eopIrqEn  = ($urandom % 4) != 0;
      intrReset = ($urandom % 25) == 0;
    end
    idle(3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule